// File: doc/BRIEF.md
# Strong Pull-Up Hold Controller

This block sits on the master side of a single-wire sensor bus, next to the byte engine that shifts command bytes out. It watches every byte the engine finishes sending. When the byte asks a device to start a temperature conversion or to copy its scratchpad into non-volatile storage, the device draws more current than the weak pull-up resistor can supply. For these two codes the controller turns on a strong pull-up enable one clock after the byte completes. It keeps the enable on for the hold time that belongs to that command, then releases it.

While the pull-up is on, nothing else may use the bus. The controller raises a bus inhibit for the whole hold. A new transfer request from the master's sequencer is only granted when the inhibit is low. A request that arrives during a hold is remembered. It is granted in the cycle the hold ends, which is the same cycle as the one-cycle done pulse.

Hold times are set in microseconds and scaled by a clocks-per-microsecond parameter, so a testbench can shorten them. The states are:
- `ST_IDLE`: waiting for a byte.
- `ST_HOLD_CONV`: holding after a conversion command.
- `ST_HOLD_COPY`: holding after a copy command.

The transitions are:
- Idle to conversion hold, on a byte strobe carrying 44h.
- Idle to copy hold, on a byte strobe carrying 48h.
- Either hold to idle, when the hold timer reaches zero.

Top module: `spu_hold_ctrl`

## Requirements
- R1: During and after reset, until a trigger byte arrives, `spu_en`, `bus_inhibit`, `done_pulse` and `xfer_go` are all 0.
- R2: A `byte_done` strobe with `byte_val` = 8'h44 while idle sets `spu_en` and `bus_inhibit` to 1 in the next clock cycle, well inside the 10 us deadline for any `CYC_PER_US` of 1 or more.
- R3: A `byte_done` strobe with `byte_val` = 8'h48 while idle sets `spu_en` and `bus_inhibit` to 1 in the next clock cycle.
- R4: After 8'h44, `spu_en` stays high for exactly `CONV_US*CYC_PER_US` clock cycles.
- R5: After 8'h48, `spu_en` stays high for exactly `COPY_US*CYC_PER_US` clock cycles.
- R6: A `byte_done` strobe with any other byte value leaves `spu_en` and `bus_inhibit` low.
- R7: Byte strobes that arrive during a hold, trigger codes included, neither restart nor lengthen the hold.
- R8: When a hold ends, `spu_en` and `bus_inhibit` fall in the same cycle, and `done_pulse` is high for exactly that one cycle.
- R9: An `xfer_req` pulse while idle produces a one-cycle `xfer_go` in the next cycle.
- R10: An `xfer_req` that arrives while `bus_inhibit` is high produces exactly one `xfer_go`, in the cycle of `done_pulse`. `xfer_go` is never high while `bus_inhibit` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_done | input | 1 | One-cycle strobe: a command byte has finished on the bus |
| byte_val | input | 8 | Value of the byte just sent |
| xfer_req | input | 1 | One-cycle request to start a bus transfer |
| spu_en | output | 1 | Strong pull-up enable |
| bus_inhibit | output | 1 | High while no other bus traffic is allowed |
| done_pulse | output | 1 | One-cycle pulse when a hold ends |
| xfer_go | output | 1 | One-cycle grant for a transfer request |

## Verification
Some properties are checked by assertions on every cycle:
- A trigger byte in idle enables the pull-up on the next edge, and any other byte leaves it off.
- The inhibit never falls without a done pulse.
- A grant is never given while the bus is inhibited.
- No hold runs longer than the conversion time.

Other behaviour can only be shown by the bench's scenarios, which compare event cycles against a scoreboard:
- Each hold lasts its exact length.
- Bytes sent during a hold are ignored.
- A request made during a hold is deferred to the done cycle and granted only once.

// File: rtl/spu_pkg.sv
package spu_pkg;
    localparam logic [7:0] OPC_CONVERT = 8'h44;
    localparam logic [7:0] OPC_COPY    = 8'h48;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_HOLD_CONV = 2'd1,
        ST_HOLD_COPY = 2'd2
    } spu_state_t;

    typedef enum logic [1:0] {
        CMD_OTHER   = 2'd0,
        CMD_CONVERT = 2'd1,
        CMD_COPY    = 2'd2
    } spu_cmd_t;
endpackage

// File: rtl/spu_cmd_decode.sv
module spu_cmd_decode
    import spu_pkg::*;
(
    input  logic [7:0] opc,
    output spu_cmd_t   kind
);
    always_comb begin
        unique case (opc)
            OPC_CONVERT: kind = CMD_CONVERT;
            OPC_COPY:    kind = CMD_COPY;
            default:     kind = CMD_OTHER;
        endcase
    end
endmodule

// File: rtl/spu_hold_timer.sv
module spu_hold_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/spu_hold_ctrl.sv
module spu_hold_ctrl
    import spu_pkg::*;
#(
    parameter int CYC_PER_US = 50,
    parameter int CONV_US    = 750000,
    parameter int COPY_US    = 10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_done,
    input  logic [7:0] byte_val,
    input  logic       xfer_req,
    output logic       spu_en,
    output logic       bus_inhibit,
    output logic       done_pulse,
    output logic       xfer_go
);
    localparam int CONV_CYC = CONV_US * CYC_PER_US;
    localparam int COPY_CYC = COPY_US * CYC_PER_US;
    localparam int MAX_CYC  = (CONV_CYC > COPY_CYC) ? CONV_CYC : COPY_CYC;
    localparam int TW       = $clog2(MAX_CYC + 1);
    localparam logic [TW-1:0] CONV_LOAD = TW'(CONV_CYC - 1);
    localparam logic [TW-1:0] COPY_LOAD = TW'(COPY_CYC - 1);

    spu_state_t    state_q, state_n;
    spu_cmd_t      kind;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          pend_q;
    logic          want_go;

    spu_cmd_decode u_dec (
        .opc  (byte_val),
        .kind (kind)
    );

    spu_hold_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // Next state and timer load
    always_comb begin
        state_n  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (byte_done && kind == CMD_CONVERT) begin
                    state_n  = ST_HOLD_CONV;
                    tmr_load = 1'b1;
                    tmr_val  = CONV_LOAD;
                end else if (byte_done && kind == CMD_COPY) begin
                    state_n  = ST_HOLD_COPY;
                    tmr_load = 1'b1;
                    tmr_val  = COPY_LOAD;
                end
            end
            ST_HOLD_CONV, ST_HOLD_COPY: begin
                if (tmr_zero)
                    state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_n;
    end

    assign want_go = xfer_req || pend_q;

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spu_en      <= 1'b0;
            bus_inhibit <= 1'b0;
            done_pulse  <= 1'b0;
            xfer_go     <= 1'b0;
            pend_q      <= 1'b0;
        end else begin
            spu_en      <= (state_n != ST_IDLE);
            bus_inhibit <= (state_n != ST_IDLE);
            done_pulse  <= (state_q != ST_IDLE) && (state_n == ST_IDLE);
            xfer_go     <= want_go && (state_n == ST_IDLE);
            pend_q      <= want_go && (state_n != ST_IDLE);
        end
    end

    // Hold-length watch used by the bound check
    logic [TW:0] hold_len_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_len_q <= '0;
        else if (spu_en)
            hold_len_q <= hold_len_q + 1'b1;
        else
            hold_len_q <= '0;
    end

    a_r2_convert_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && byte_val == OPC_CONVERT && !bus_inhibit) |=> (spu_en && bus_inhibit));

    a_r3_copy_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && byte_val == OPC_COPY && !bus_inhibit) |=> (spu_en && bus_inhibit));

    a_r6_other_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && byte_val != OPC_CONVERT && byte_val != OPC_COPY && !bus_inhibit)
        |=> !spu_en);

    a_r8_release_has_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_inhibit) |-> done_pulse);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    a_r10_no_go_inhibited: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go |-> !bus_inhibit);

    a_r4_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
        hold_len_q <= (TW+1)'(MAX_CYC));
endmodule

// File: tb/spu_hold_ctrl_tb_top.sv
module spu_hold_ctrl_tb_top;
    localparam int CPU   = 2;
    localparam int CONVU = 40;
    localparam int COPYU = 10;
    localparam int NCONV = CPU * CONVU;
    localparam int NCOPY = CPU * COPYU;

    localparam int EV_RISE = 1;
    localparam int EV_DONE = 2;
    localparam int EV_GO   = 3;

    typedef struct {
        int    kind;
        int    cyc;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_done = 1'b0;
    logic [7:0] byte_val = 8'h00;
    logic       xfer_req = 1'b0;
    logic       spu_en, bus_inhibit, done_pulse, xfer_go;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_errors = 0;
    exp_t q[$];
    logic prev_en = 1'b0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spu_hold_ctrl #(.CYC_PER_US(CPU), .CONV_US(CONVU), .COPY_US(COPYU)) dut_i (
        .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_val(byte_val),
        .xfer_req(xfer_req), .spu_en(spu_en), .bus_inhibit(bus_inhibit),
        .done_pulse(done_pulse), .xfer_go(xfer_go)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic expect_ev(input int kind, input int at, input string req);
        exp_t e;
        e.kind = kind; e.cyc = at; e.req = req;
        q.push_back(e);
    endtask

    // Monitor: turns output activity into events and pops the scoreboard
    task automatic observe(input int kind);
        exp_t e;
        if (q.size() == 0) begin
            check(1'b0, "unexpected event", kind, 0);
        end else begin
            e = q.pop_front();
            check(e.kind == kind, e.req, kind, e.kind);
            check(e.cyc == cyc, e.req, cyc, e.cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (spu_en && !prev_en) observe(EV_RISE);
            if (done_pulse)         observe(EV_DONE);
            if (xfer_go)            observe(EV_GO);
            if (bus_inhibit != spu_en)
                check(1'b0, "R8 inhibit tracks enable", bus_inhibit, spu_en);
            if (xfer_go && bus_inhibit)
                check(1'b0, "R10 grant while inhibited", 1, 0);
            prev_en = spu_en;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive one byte strobe; returns the cycle at which a hold would end
    task automatic send_byte(input logic [7:0] v, output int done_at);
        @(negedge clk);
        byte_done = 1'b1;
        byte_val  = v;
        done_at   = 0;
        if (!bus_inhibit && v == 8'h44) begin
            expect_ev(EV_RISE, cyc + 1, "R2 convert enable next cycle");
            done_at = cyc + 1 + NCONV;
            expect_ev(EV_DONE, done_at, "R4 R8 convert hold length");
        end else if (!bus_inhibit && v == 8'h48) begin
            expect_ev(EV_RISE, cyc + 1, "R3 copy enable next cycle");
            done_at = cyc + 1 + NCOPY;
            expect_ev(EV_DONE, done_at, "R5 R8 copy hold length");
        end
        @(negedge clk);
        byte_done = 1'b0;
        byte_val  = 8'h00;
    endtask

    task automatic send_req(input int go_at, input string req);
        @(negedge clk);
        xfer_req = 1'b1;
        expect_ev(EV_GO, (go_at == 0) ? cyc + 1 : go_at, req);
        @(negedge clk);
        xfer_req = 1'b0;
    endtask

    initial begin
        int d1, d2, dummy;
        idle(3);
        check(spu_en == 1'b0 && bus_inhibit == 1'b0, "R1 reset enable", spu_en, 0);
        check(done_pulse == 1'b0 && xfer_go == 1'b0, "R1 reset pulses", done_pulse, 0);
        rst_n = 1'b1;
        idle(3);
        check(spu_en == 1'b0 && xfer_go == 1'b0, "R1 idle after reset", spu_en, 0);

        // R9 request while idle
        send_req(0, "R9 grant next cycle");
        idle(3);

        // R2 R4 conversion hold, with R7 stray bytes and R10 deferred request
        send_byte(8'h44, d1);
        idle(5);
        send_byte(8'h48, dummy);   // R7 ignored
        send_byte(8'h44, dummy);   // R7 ignored
        send_byte(8'hCC, dummy);
        send_req(d1, "R10 deferred grant at done");
        send_req(d1, "R10 second deferred request merges");
        q.delete(q.size() - 1);   // merged: only one grant expected
        idle(NCONV + 5);
        check(spu_en == 1'b0, "R8 released after convert", spu_en, 0);

        // R3 R5 copy hold
        send_byte(8'h48, d2);
        idle(3);
        check(spu_en == 1'b1 && bus_inhibit == 1'b1, "R3 enable held", spu_en, 1);
        idle(NCOPY + 3);
        check(spu_en == 1'b0, "R5 released after copy", spu_en, 0);

        // R6 other codes
        send_byte(8'hBE, dummy);
        idle(1);
        check(spu_en == 1'b0, "R6 BEh no enable", spu_en, 0);
        send_byte(8'h4E, dummy);
        idle(1);
        check(spu_en == 1'b0, "R6 4Eh no enable", spu_en, 0);
        send_byte(8'h45, dummy);
        idle(1);
        check(bus_inhibit == 1'b0, "R6 45h no inhibit", bus_inhibit, 0);

        // R9 again after everything
        send_req(0, "R9 grant after holds");
        idle(4);

        check(q.size() == 0, "scoreboard drained", q.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule